// File: doc/BRIEF.md
# Runahead Mode Controller

This block decides when an out-of-order core stops waiting on a long memory miss and instead runs ahead speculatively, and when it returns to normal execution. It looks at the instruction at the head of the window each cycle. When that instruction is waiting on a level-2 cache miss and the entry filters agree, it pulses a checkpoint request and switches into runahead mode. It remembers which miss caused the switch. When that same miss returns its data, it pulses a checkpoint restore and a pipeline flush and goes back to normal mode.

While in runahead mode the controller decides when the head instruction leaves the window. A head marked invalid (its result depends on a missing load) leaves at once. A valid head leaves only after it has completed. No architectural commit is allowed in this mode. Two filters reject entries that would give little benefit. The first refuses a miss that has already been in flight longer than a programmable cycle limit. The second refuses entry until the number of instructions fetched since the previous period ended has caught up with the number removed during that period.

Top module: `runahead_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs are as follows: mode is normal (0), and checkpoint save, restore, flush, head pop and commit are all 0.
- R2: Entry is only possible when the head is valid, its L2-miss flag is 1, and the mode is normal. On the clock edge that samples such a head, the block starts runahead mode. From that edge on, mode reads 1 and checkpoint save is 1 for exactly one cycle. A head without the miss flag never causes entry.
- R3: Runahead mode exits when a miss return arrives whose ID equals the ID of the miss that caused entry. At the next edge, mode drops to 0. In that same cycle, restore and flush are each 1 for exactly one cycle.
- R4: A miss return with any other ID has no effect on the mode.
- R5: In runahead mode, a valid head leaves the window (head pop = 1) in the same cycle if its invalid flag is 1. If the invalid flag is 0, it leaves only in a cycle where its done flag is 1.
- R6: In normal mode, a valid head with done = 1 gives head pop = 1 and commit = 1 in the same cycle. In runahead mode, commit is always 0.
- R7: Each miss ID has its own age count. A miss issue sets its count to 0. After that, the count grows by one on every edge until that ID's miss returns. Entry is refused when the head's age is greater than the age-limit input. Entry is allowed when the age equals the limit. The limit can be changed at any cycle.
- R8: Age counts saturate at 2^AGE_W - 1 instead of wrapping. A miss that has been in flight for a very long time stays refused for any limit below that maximum.
- R9: Each period counts its head pops (R). After a period ends, the block counts fetch strobes seen in normal mode (N). Entry is refused while N < R. Both counts start at zero after reset.
- R10: Exit wins over entry. No checkpoint save appears in the cycle the exit takes effect, nor in the cycle right after the flush pulse. Entry is possible again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_vld | input | 1 | Window head holds an instruction |
| head_l2miss | input | 1 | Head is waiting on an L2 miss |
| head_miss_id | input | ID_W | Miss ID of the head's L2 miss |
| head_done | input | 1 | Head has completed execution |
| head_inv | input | 1 | Head result is marked invalid (miss dependent) |
| miss_iss_vld | input | 1 | An L2 miss is issued this cycle |
| miss_iss_id | input | ID_W | ID of the issued miss |
| miss_rtn_vld | input | 1 | A miss returns its data this cycle |
| miss_rtn_id | input | ID_W | ID of the returning miss |
| fetch_evt | input | 1 | One instruction was fetched this cycle |
| age_limit | input | AGE_W | Largest miss age that may still trigger entry |
| ra_mode | output | 1 | 1 while in runahead mode |
| ckpt_save | output | 1 | One-cycle request to checkpoint registers |
| ckpt_restore | output | 1 | One-cycle request to restore the checkpoint |
| pipe_flush | output | 1 | One-cycle pipeline flush at exit |
| head_pop | output | 1 | Head leaves the window this cycle |
| commit_en | output | 1 | Head updates architectural state this cycle |

## Verification
A wrong trigger ID is visible at the ports on the first return that follows. The mode either fails to drop on the matching return, or drops on a stray one, and the restore and flush pulses come one cycle later. A wrong age count or period count shows up as a checkpoint save that appears one cycle too early, or never appears, when a miss head is held across the boundary cycle. The bench holds a miss head across exactly that cycle. A mode register stuck high shows up at once, either as commit being 0 for a completed head in normal mode or as the wrong pop rule being applied.

// File: rtl/ra_ctrl_pkg.sv
package ra_ctrl_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_AHEAD  = 1'b1
  } ra_mode_e;

  // Counter step that sticks at the limit instead of wrapping.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

  // A miss older than the limit may not start a period.
  function automatic logic age_exceeds(input logic [31:0] age, input logic [31:0] lim);
    return age > lim;
  endfunction

  // Fetched-since-exit must have caught up with popped-during-period.
  function automatic logic reentry_ok(input logic [31:0] fetched, input logic [31:0] popped);
    return fetched >= popped;
  endfunction

endpackage

// File: rtl/ra_miss_age.sv
module ra_miss_age
  import ra_ctrl_pkg::*;
#(
  parameter int NUM_IDS = 8,
  parameter int ID_W    = 3,
  parameter int AGE_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_vld,
  input  logic [ID_W-1:0]  iss_id,
  input  logic             rtn_vld,
  input  logic [ID_W-1:0]  rtn_id,
  input  logic [ID_W-1:0]  look_id,
  input  logic [AGE_W-1:0] limit,
  output logic             age_over
);
  localparam logic [31:0] AGE_MAX = (32'd1 << AGE_W) - 32'd1;

  logic [NUM_IDS*AGE_W-1:0] age_flat;
  logic [AGE_W-1:0]         look_age;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    logic             busy_q;
    logic [AGE_W-1:0] age_q;
    logic             iss_hit;
    logic             rtn_hit;

    assign iss_hit = iss_vld && (iss_id == ID_W'(g));
    assign rtn_hit = rtn_vld && (rtn_id == ID_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        age_q  <= '0;
      end else if (iss_hit) begin
        busy_q <= 1'b1;
        age_q  <= '0;
      end else if (rtn_hit) begin
        busy_q <= 1'b0;
        age_q  <= '0;
      end else if (busy_q) begin
        age_q  <= AGE_W'(sat_inc(32'(age_q), AGE_MAX));
      end
    end

    assign age_flat[g*AGE_W +: AGE_W] = age_q;
  end

  assign look_age = age_flat[int'(look_id)*AGE_W +: AGE_W];
  assign age_over = age_exceeds(32'(look_age), 32'(limit));

endmodule

// File: rtl/ra_period_cnt.sv
module ra_period_cnt
  import ra_ctrl_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_ahead,
  input  logic enter,
  input  logic leave,
  input  logic pop,
  input  logic fetch,
  output logic n_ge_r
);
  localparam logic [31:0] CNT_MAX = (32'd1 << CNT_W) - 32'd1;

  logic [CNT_W-1:0] popped_q;
  logic [CNT_W-1:0] fetched_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      popped_q <= '0;
    end else if (enter) begin
      popped_q <= '0;
    end else if (in_ahead && pop) begin
      popped_q <= CNT_W'(sat_inc(32'(popped_q), CNT_MAX));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetched_q <= '0;
    end else if (leave) begin
      fetched_q <= '0;
    end else if (!in_ahead && fetch) begin
      fetched_q <= CNT_W'(sat_inc(32'(fetched_q), CNT_MAX));
    end
  end

  assign n_ge_r = reentry_ok(32'(fetched_q), 32'(popped_q));

endmodule

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
  import ra_ctrl_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            entry_req,
  input  logic [ID_W-1:0] head_id,
  input  logic            rtn_vld,
  input  logic [ID_W-1:0] rtn_id,
  output logic            in_ahead,
  output logic            entry_fire,
  output logic            exit_fire,
  output logic [ID_W-1:0] trig_id,
  output logic            save_pls,
  output logic            restore_pls,
  output logic            flush_pls
);
  ra_mode_e        mode_q;
  logic [ID_W-1:0] trig_q;
  logic            save_q;
  logic            restore_q;
  logic            flush_q;

  assign in_ahead   = (mode_q == MODE_AHEAD);
  assign exit_fire  = in_ahead && rtn_vld && (rtn_id == trig_q);
  // Exit first; the flush cycle also keeps a new period from starting.
  assign entry_fire = !in_ahead && !flush_q && entry_req && !exit_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_NORMAL;
      trig_q    <= '0;
      save_q    <= 1'b0;
      restore_q <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      save_q    <= 1'b0;
      restore_q <= 1'b0;
      flush_q   <= 1'b0;
      if (exit_fire) begin
        mode_q    <= MODE_NORMAL;
        restore_q <= 1'b1;
        flush_q   <= 1'b1;
      end else if (entry_fire) begin
        mode_q <= MODE_AHEAD;
        trig_q <= head_id;
        save_q <= 1'b1;
      end
    end
  end

  assign trig_id     = trig_q;
  assign save_pls    = save_q;
  assign restore_pls = restore_q;
  assign flush_pls   = flush_q;

endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
  import ra_ctrl_pkg::*;
#(
  parameter  int NUM_IDS = 8,
  parameter  int AGE_W   = 10,
  parameter  int CNT_W   = 12,
  localparam int ID_W    = $clog2(NUM_IDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_vld,
  input  logic             head_l2miss,
  input  logic [ID_W-1:0]  head_miss_id,
  input  logic             head_done,
  input  logic             head_inv,
  input  logic             miss_iss_vld,
  input  logic [ID_W-1:0]  miss_iss_id,
  input  logic             miss_rtn_vld,
  input  logic [ID_W-1:0]  miss_rtn_id,
  input  logic             fetch_evt,
  input  logic [AGE_W-1:0] age_limit,
  output logic             ra_mode,
  output logic             ckpt_save,
  output logic             ckpt_restore,
  output logic             pipe_flush,
  output logic             head_pop,
  output logic             commit_en
);
  // Named internal events, observed by the bound checker.
  logic            age_over;
  logic            n_ge_r;
  logic            entry_req;
  logic            entry_fire;
  logic            exit_fire;
  logic            in_ahead;
  logic [ID_W-1:0] trig_id;

  ra_miss_age #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .AGE_W(AGE_W)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_vld  (miss_iss_vld),
    .iss_id   (miss_iss_id),
    .rtn_vld  (miss_rtn_vld),
    .rtn_id   (miss_rtn_id),
    .look_id  (head_miss_id),
    .limit    (age_limit),
    .age_over (age_over)
  );

  assign entry_req = head_vld && head_l2miss && !age_over && n_ge_r;

  ra_mode_fsm #(.ID_W(ID_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_req   (entry_req),
    .head_id     (head_miss_id),
    .rtn_vld     (miss_rtn_vld),
    .rtn_id      (miss_rtn_id),
    .in_ahead    (in_ahead),
    .entry_fire  (entry_fire),
    .exit_fire   (exit_fire),
    .trig_id     (trig_id),
    .save_pls    (ckpt_save),
    .restore_pls (ckpt_restore),
    .flush_pls   (pipe_flush)
  );

  // Pseudo-retire in runahead: invalid heads drop at once, valid ones on done.
  always_comb begin
    if (in_ahead) begin
      head_pop  = head_vld && (head_inv || head_done);
      commit_en = 1'b0;
    end else begin
      head_pop  = head_vld && head_done;
      commit_en = head_vld && head_done;
    end
  end

  ra_period_cnt #(.CNT_W(CNT_W)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ahead (in_ahead),
    .enter    (entry_fire),
    .leave    (exit_fire),
    .pop      (head_pop),
    .fetch    (fetch_evt),
    .n_ge_r   (n_ge_r)
  );

  assign ra_mode = in_ahead;

endmodule

// File: rtl/ra_ctrl_chk.sv
module ra_ctrl_chk #(
  parameter int ID_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            head_vld,
  input logic            head_l2miss,
  input logic            head_inv,
  input logic            miss_rtn_vld,
  input logic [ID_W-1:0] miss_rtn_id,
  input logic            ra_mode,
  input logic            ckpt_save,
  input logic            ckpt_restore,
  input logic            pipe_flush,
  input logic            head_pop,
  input logic            commit_en,
  input logic [ID_W-1:0] trig_id,
  input logic            age_over,
  input logic            n_ge_r
);
  p_save_needs_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_save |-> $past(head_vld && head_l2miss));
  p_save_starts_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_save |-> (ra_mode && !$past(ra_mode)));
  p_exit_pulses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ra_mode) |-> (ckpt_restore && pipe_flush));
  p_flush_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |=> !pipe_flush);
  p_stray_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode && !(miss_rtn_vld && miss_rtn_id == trig_id)) |=> ra_mode);
  p_inv_pops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode && head_vld && head_inv) |-> head_pop);
  p_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ra_mode |-> !commit_en);
  p_age_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_save |-> !$past(age_over));
  p_reentry_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_save |-> $past(n_ge_r));
  p_flush_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |=> !ckpt_save);
endmodule

bind runahead_ctrl ra_ctrl_chk #(.ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .head_vld     (head_vld),
  .head_l2miss  (head_l2miss),
  .head_inv     (head_inv),
  .miss_rtn_vld (miss_rtn_vld),
  .miss_rtn_id  (miss_rtn_id),
  .ra_mode      (ra_mode),
  .ckpt_save    (ckpt_save),
  .ckpt_restore (ckpt_restore),
  .pipe_flush   (pipe_flush),
  .head_pop     (head_pop),
  .commit_en    (commit_en),
  .trig_id      (trig_id),
  .age_over     (age_over),
  .n_ge_r       (n_ge_r)
);

// File: tb/test_runahead_ctrl.sv
module test_runahead_ctrl;
  localparam int NUM_IDS = 8;
  localparam int AGE_W   = 10;
  localparam int ID_W    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic head_vld, head_l2miss, head_done, head_inv;
  logic [ID_W-1:0] head_miss_id, miss_iss_id, miss_rtn_id;
  logic miss_iss_vld, miss_rtn_vld, fetch_evt;
  logic [AGE_W-1:0] age_limit;
  logic ra_mode, ckpt_save, ckpt_restore, pipe_flush, head_pop, commit_en;

  always #2 clk = ~clk;

  runahead_ctrl #(.NUM_IDS(NUM_IDS), .AGE_W(AGE_W), .CNT_W(12)) i_runahead_ctrl (
    .clk(clk), .rst_n(rst_n),
    .head_vld(head_vld), .head_l2miss(head_l2miss), .head_miss_id(head_miss_id),
    .head_done(head_done), .head_inv(head_inv),
    .miss_iss_vld(miss_iss_vld), .miss_iss_id(miss_iss_id),
    .miss_rtn_vld(miss_rtn_vld), .miss_rtn_id(miss_rtn_id),
    .fetch_evt(fetch_evt), .age_limit(age_limit),
    .ra_mode(ra_mode), .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore),
    .pipe_flush(pipe_flush), .head_pop(head_pop), .commit_en(commit_en)
  );

  // Expected output vector {mode, save, restore, flush, pop, commit}.
  typedef struct {
    logic [5:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Monitor: compares every queued expectation at the falling edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [5:0] got;
      it  = sb_q.pop_front();
      got = {ra_mode, ckpt_save, ckpt_restore, pipe_flush, head_pop, commit_en};
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
      end
    end
  end

  // Advance to just after the next rising edge and drop strobes.
  task automatic cyc();
    @(posedge clk);
    #1;
    head_vld = 0; head_l2miss = 0; head_miss_id = '0; head_done = 0; head_inv = 0;
    miss_iss_vld = 0; miss_iss_id = '0; miss_rtn_vld = 0; miss_rtn_id = '0;
    fetch_evt = 0;
  endtask

  task automatic push(input logic [5:0] e, input string tag);
    sb_item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic miss_head(input int id);
    head_vld = 1; head_l2miss = 1; head_miss_id = ID_W'(id);
  endtask

  task automatic issue(input int id);
    miss_iss_vld = 1; miss_iss_id = ID_W'(id);
  endtask

  task automatic ret(input int id);
    miss_rtn_vld = 1; miss_rtn_id = ID_W'(id);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    head_vld = 0; head_l2miss = 0; head_miss_id = '0; head_done = 0; head_inv = 0;
    miss_iss_vld = 0; miss_iss_id = '0; miss_rtn_vld = 0; miss_rtn_id = '0;
    fetch_evt = 0; age_limit = 10'd10;

    cyc(); push(6'b000000, "R1 during reset");
    cyc(); rst_n = 1'b1; push(6'b000000, "R1 first cycle after reset");

    cyc(); head_vld = 1; head_done = 1; push(6'b000011, "R6 normal commit");
    cyc(); head_vld = 1; push(6'b000000, "R2 non-miss head");
    cyc(); push(6'b000000, "R2 no entry without miss flag");

    // First period, triggered by miss 2.
    cyc(); issue(2); push(6'b000000, "R2 issue");
    cyc(); miss_head(2); push(6'b000000, "R2 miss head sampled");
    cyc(); head_vld = 1; head_inv = 1; push(6'b110010, "R2 R5 entry and invalid pop");
    cyc(); head_vld = 1; push(6'b100000, "R5 valid head waits");
    cyc(); head_vld = 1; head_done = 1; push(6'b100010, "R5 R6 done pops, no commit");
    cyc(); ret(5); push(6'b100000, "R4 stray return cycle");
    cyc(); push(6'b100000, "R4 mode held after stray return");
    cyc(); ret(2); push(6'b100000, "R3 matching return cycle");
    cyc(); push(6'b001100, "R3 exit pulses");
    cyc(); push(6'b000000, "R3 pulses last one cycle");

    // Period popped 2; entry waits for 2 fetches.
    cyc(); issue(4); push(6'b000000, "R9 issue");
    cyc(); miss_head(4); fetch_evt = 1; push(6'b000000, "R9 blocked N=0");
    cyc(); miss_head(4); fetch_evt = 1; push(6'b000000, "R9 blocked N=1");
    cyc(); miss_head(4); push(6'b000000, "R9 N reaches R");
    cyc(); push(6'b110000, "R9 entry once N>=R");
    cyc(); ret(4); push(6'b100000, "R3 return 4");
    cyc(); push(6'b001100, "R3 exit 4");
    cyc(); push(6'b000000, "R3 idle after exit 4");

    // Age limit boundary with a programmable limit.
    cyc(); age_limit = 10'd2; issue(7); push(6'b000000, "R7 issue 7");
    cyc(); push(6'b000000, "R7 aging");
    cyc(); push(6'b000000, "R7 aging");
    cyc(); push(6'b000000, "R7 aging");
    cyc(); miss_head(7); push(6'b000000, "R7 age 3 limit 2");
    cyc(); miss_head(7); age_limit = 10'd4; push(6'b000000, "R7 refused when age above limit");
    cyc(); push(6'b110000, "R7 entry at age equal to limit");

    // Exit wins, flush cycle blocks entry.
    cyc(); ret(7); miss_head(6); push(6'b100000, "R10 return with miss head");
    cyc(); miss_head(6); push(6'b001100, "R10 no save on exit edge");
    cyc(); miss_head(6); push(6'b000000, "R10 no save after flush cycle");
    cyc(); push(6'b110000, "R10 entry one cycle later");
    cyc(); ret(6); push(6'b100000, "R3 return 6");
    cyc(); push(6'b001100, "R3 exit 6");
    cyc(); push(6'b000000, "R3 idle after exit 6");

    // Saturated age stays above any lower limit.
    cyc(); age_limit = 10'd1022; issue(3);
    for (int i = 0; i < 1100; i++) cyc();
    cyc(); miss_head(3); push(6'b000000, "R8 saturated head sampled");
    cyc(); miss_head(3); age_limit = 10'd1023; push(6'b000000, "R8 refused at 1023 over 1022");
    cyc(); push(6'b110000, "R8 entry with limit at maximum");
    cyc(); ret(3); push(6'b100000, "R3 return 3");
    cyc(); push(6'b001100, "R3 exit 3");

    @(negedge clk);
    #1;
    finish_run();
  end

endmodule